// File: doc/BRIEF.md
# Two-Ramp Alternating PWM Generator

This block drives two PWM lines from a single up-counter that takes turns between two ramps. In the first ramp (ramp A) the counter climbs from zero to a ramp-A top value. It then restarts at zero for the second ramp (ramp B), which climbs to a period value. After ramp B the sequence returns to ramp A. Ramp A drives output 0 and ramp B drives output 1. Each output has its own duty compare value and its own inversion bit. Because the two tops are independent, the two ramps can differ in length. Both waveforms share one counter, and no value rotates through a circular buffer.

The counter advances only on cycles where the prescaler's clock-enable is high and the run input is high. Software writes the top, period and compare values through a small write port into shadow registers. Those values reach the working registers only at the first cycle of the next ramp A, or at any time while the block is stopped. A ramp flag and two single-cycle start strobes let surrounding logic follow the sequence.

Top module: `dual_ramp_pwm`

## Requirements
- R1: While `run` is low the counter is held at zero in ramp A. `ramp_b_o` is 0, both start strobes are 0 and each output equals its inversion bit. The same state applies after reset.
- R2: While `run` is high the counter rises by one on each clock where `tick` is high and holds its value when `tick` is low.
- R3: Ramp A covers counter values 0 up to and including the working ramp-A top. On the next tick ramp B begins at zero, so ramp A lasts top+1 ticks.
- R4: Ramp B covers counter values 0 up to and including the working period. On the next tick ramp A begins again at zero.
- R5: With inversion bit 0, an output is high during its own ramp while the counter is below its compare value, and low from the compare value to the end of that ramp. Output 0 owns ramp A and uses compare select 2. Output 1 owns ramp B and uses compare select 3.
- R6: During the ramp it does not own, each output sits at its inactive level, which equals its inversion bit.
- R7: `pol[i]` inverts output `i` and takes effect in the same cycle it changes.
- R8: A write with `wr_en` high stores `wr_data` into the shadow register chosen by `wr_sel`: 0 for the ramp-A top, 1 for the period, 2 for the compare of output 0, 3 for the compare of output 1. Shadow values move to the working registers only on entry to ramp A after ramp B, or on any clock while `run` is low.
- R9: `start_a_o` and `start_b_o` are high for exactly the first cycle of a ramp entered by a wrap, are never high together, and do not fire when `run` rises.
- R10: With ramp-A top 2500, period 5000 and both compares 1250, each output is active for 1250 cycles of every 7502-cycle ramp pair when `tick` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock-enable from the prescaler |
| run | input | 1 | Enable. Low holds the counter at zero in ramp A |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 2 | Shadow register select (0 top A, 1 period, 2 compare 0, 3 compare 1) |
| wr_data | input | CNT_W | Value to write |
| pol | input | 2 | Per-output inversion bits |
| wave_o | output | 2 | Waveform outputs, bit 0 for ramp A and bit 1 for ramp B |
| ramp_b_o | output | 1 | Current ramp, 0 for A and 1 for B |
| start_a_o | output | 1 | One-cycle strobe in the first cycle of ramp A |
| start_b_o | output | 1 | One-cycle strobe in the first cycle of ramp B |

## Verification
The waveform outputs are combinational from the registered counter state and `pol`. An inversion change therefore shows in the same cycle, while a counter step or ramp change appears after the one rising edge on which `tick` was sampled. The ramp flag and both strobes change on that same edge, so a strobe marks the first cycle of the new ramp. A shadow write lands one edge after `wr_en` but reaches the outputs only from the first cycle of the next ramp A. The bench drives inputs on the falling edge and compares all outputs 1 ns after each rising edge. At that point the registered state has settled and the inputs used at that edge are still present. The directed checks count edges against these latencies, including a mid-ramp write that must leave the rest of the current ramp A unchanged.

// File: rtl/dual_ramp_pkg.sv
package dual_ramp_pkg;

  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned NUM_OUT  = 2;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);

  // Shadow/working register slots, as decoded from wr_sel
  localparam int unsigned IDX_TOP_A  = 0;
  localparam int unsigned IDX_PERIOD = 1;
  localparam int unsigned IDX_CMP0   = 2;

  typedef enum logic {
    RAMP_A = 1'b0,
    RAMP_B = 1'b1
  } ramp_e;

  // Level of a waveform line: active only while its ramp runs and the
  // counter is still below the compare value, then optionally inverted.
  function automatic logic wave_level(input logic owns, input logic below,
                                      input logic inv);
    return inv ^ (owns & below);
  endfunction

endpackage

// File: rtl/dual_ramp_regs.sv
module dual_ramp_regs
  import dual_ramp_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [SEL_W-1:0]                   wr_sel,
  input  logic [CNT_W-1:0]                   wr_data,
  input  logic                               load,
  output logic [NUM_REGS-1:0][CNT_W-1:0]     act_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic [CNT_W-1:0] shd;
    logic [CNT_W-1:0] act;
    logic             hit;

    assign hit = wr_en && (wr_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd <= '0;
      end else if (hit) begin
        shd <= wr_data;
      end
    end

    // Working copy follows the shadow only at a ramp-A boundary or when idle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act <= '0;
      end else if (load) begin
        act <= shd;
      end
    end

    assign act_q[i] = act;
  end

endmodule

// File: rtl/dual_ramp_counter.sv
module dual_ramp_counter
  import dual_ramp_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] top_a,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ramp_b_q,
  output logic             start_a_q,
  output logic             start_b_q,
  output logic             load_o
);

  ramp_e            ramp_q;
  logic [CNT_W-1:0] cur_top;
  logic             end_hit;

  function automatic logic ramp_done(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] top);
    return c == top;
  endfunction

  assign cur_top  = (ramp_q == RAMP_B) ? period : top_a;
  assign end_hit  = run && tick && ramp_done(cnt_q, cur_top);
  // Working registers reload when stopped, or on the B-to-A wrap edge
  assign load_o   = !run || (end_hit && (ramp_q == RAMP_B));
  assign ramp_b_q = (ramp_q == RAMP_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ramp_q <= RAMP_A;
    end else if (!run) begin
      cnt_q  <= '0;
      ramp_q <= RAMP_A;
    end else if (tick) begin
      if (end_hit) begin
        cnt_q  <= '0;
        ramp_q <= (ramp_q == RAMP_A) ? RAMP_B : RAMP_A;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_a_q <= 1'b0;
      start_b_q <= 1'b0;
    end else begin
      start_a_q <= end_hit && (ramp_q == RAMP_B);
      start_b_q <= end_hit && (ramp_q == RAMP_A);
    end
  end

endmodule

// File: rtl/dual_ramp_wave.sv
module dual_ramp_wave
  import dual_ramp_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             run,
  input  logic             owns,
  input  logic             inv,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             level
);

  function automatic logic below_cmp(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] limit);
    return c < limit;
  endfunction

  assign level = wave_level(run && owns, below_cmp(cnt, cmp), inv);

endmodule

// File: rtl/dual_ramp_pwm.sv
module dual_ramp_pwm
  import dual_ramp_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       pol,
  output logic [1:0]       wave_o,
  output logic             ramp_b_o,
  output logic             start_a_o,
  output logic             start_b_o
);

  logic [NUM_REGS-1:0][CNT_W-1:0] act_regs;
  logic [CNT_W-1:0]               act_top_a;
  logic [CNT_W-1:0]               act_period;
  logic [CNT_W-1:0]               cnt;
  logic                           ramp_b;
  logic                           load_req;
  logic [NUM_OUT-1:0]             owns_vec;
  logic [NUM_OUT-1:0]             wave;

  assign act_top_a  = act_regs[IDX_TOP_A];
  assign act_period = act_regs[IDX_PERIOD];

  dual_ramp_regs #(.CNT_W(CNT_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .load    (load_req),
    .act_q   (act_regs)
  );

  dual_ramp_counter #(.CNT_W(CNT_W)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (run),
    .top_a     (act_top_a),
    .period    (act_period),
    .cnt_q     (cnt),
    .ramp_b_q  (ramp_b),
    .start_a_q (start_a_o),
    .start_b_q (start_b_o),
    .load_o    (load_req)
  );

  // Output 0 belongs to ramp A, output 1 to ramp B
  assign owns_vec = {ramp_b, ~ramp_b};

  for (genvar c = 0; c < NUM_OUT; c++) begin : g_out
    dual_ramp_wave #(.CNT_W(CNT_W)) wave_i (
      .run   (run),
      .owns  (owns_vec[c]),
      .inv   (pol[c]),
      .cnt   (cnt),
      .cmp   (act_regs[IDX_CMP0 + c]),
      .level (wave[c])
    );
  end

  assign wave_o   = wave;
  assign ramp_b_o = ramp_b;

endmodule

// File: rtl/dual_ramp_pwm_chk.sv
module dual_ramp_pwm_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             ramp_b,
  input logic [CNT_W-1:0] top_a,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cmp0,
  input logic [CNT_W-1:0] cmp1,
  input logic             start_a,
  input logic             start_b,
  input logic [1:0]       wave,
  input logic [1:0]       pol
);

  a_r1_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !ramp_b && !start_a && !start_b));

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt != (ramp_b ? period : top_a)) |=> cnt == $past(cnt) + 1'b1);

  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt) && $stable(ramp_b));

  a_r3_enter_b: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !ramp_b && cnt == top_a) |=> (ramp_b && cnt == '0 && start_b));

  a_r4_enter_a: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && ramp_b && cnt == period) |=> (!ramp_b && cnt == '0 && start_a));

  a_r6_out0_idle_in_b: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_b |-> wave[0] == pol[0]);

  a_r6_out1_idle_in_a: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_b |-> wave[1] == pol[1]);

  a_r8_working_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !start_a) |->
      ($stable(top_a) && $stable(period) && $stable(cmp0) && $stable(cmp1)));

  a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_a, start_b}));

endmodule

bind dual_ramp_pwm dual_ramp_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .tick    (tick),
  .cnt     (cnt),
  .ramp_b  (ramp_b),
  .top_a   (act_top_a),
  .period  (act_period),
  .cmp0    (act_regs[2]),
  .cmp1    (act_regs[3]),
  .start_a (start_a_o),
  .start_b (start_b_o),
  .wave    (wave_o),
  .pol     (pol)
);

// File: tb/dual_ramp_pwm_tb_top.sv
module dual_ramp_pwm_tb_top;

  localparam int unsigned CW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick, run, wr_en;
  logic [1:0]    wr_sel;
  logic [CW-1:0] wr_data;
  logic [1:0]    pol;
  logic [1:0]    wave_o;
  logic          ramp_b_o, start_a_o, start_b_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  live     = 1'b0;
  bit  done     = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dual_ramp_pwm #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pol(pol),
    .wave_o(wave_o), .ramp_b_o(ramp_b_o),
    .start_a_o(start_a_o), .start_b_o(start_b_o)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model built from the requirements ----------
  logic [CW-1:0] m_shd [4];
  logic [CW-1:0] m_act [4];
  logic [CW-1:0] m_cnt;
  logic          m_rb, m_sa, m_sb;

  function automatic logic [CW-1:0] m_top(input logic rb,
                                          input logic [CW-1:0] ta,
                                          input logic [CW-1:0] per);
    return rb ? per : ta;
  endfunction

  function automatic logic exp_wave(input logic owns, input logic [CW-1:0] c,
                                    input logic [CW-1:0] cmp, input logic inv);
    if (owns && c < cmp) return ~inv;
    return inv;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_shd[i] <= '0;
        m_act[i] <= '0;
      end
      m_cnt <= '0; m_rb <= 1'b0; m_sa <= 1'b0; m_sb <= 1'b0;
    end else begin
      if (wr_en) m_shd[wr_sel] <= wr_data;   // R8 shadow write
      m_sa <= 1'b0;
      m_sb <= 1'b0;
      if (!run) begin
        m_cnt <= '0;
        m_rb  <= 1'b0;
        for (int i = 0; i < 4; i++) m_act[i] <= m_shd[i];
      end else if (tick) begin
        if (m_cnt == m_top(m_rb, m_act[0], m_act[1])) begin
          m_cnt <= '0;
          m_rb  <= ~m_rb;
          if (m_rb) begin
            m_sa <= 1'b1;
            for (int i = 0; i < 4; i++) m_act[i] <= m_shd[i];
          end else begin
            m_sb <= 1'b1;
          end
        end else begin
          m_cnt <= m_cnt + 1'b1;
        end
      end
    end
  end

  // Per-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (live) begin
      check(m_rb ? "R6 out0" : "R5 out0", 32'(wave_o[0]),
            32'(exp_wave(run && !m_rb, m_cnt, m_act[2], pol[0])));
      check(m_rb ? "R5 out1" : "R6 out1", 32'(wave_o[1]),
            32'(exp_wave(run && m_rb, m_cnt, m_act[3], pol[1])));
      check("R3 ramp flag", 32'(ramp_b_o), 32'(m_rb));
      check("R9 start_a", 32'(start_a_o), 32'(m_sa));
      check("R9 start_b", 32'(start_b_o), 32'(m_sb));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fails);
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [CW-1:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int hi0, hi1;
    logic [1:0] snap_w;
    logic       snap_r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; run = 1'b0; wr_en = 1'b0;
    wr_sel = '0; wr_data = '0; pol = 2'b00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: idle state after reset
    check("R1 wave", 32'(wave_o), 32'd0);
    check("R1 ramp", 32'(ramp_b_o), 32'd0);
    check("R1 strobes", 32'({start_a_o, start_b_o}), 32'd0);

    // R7: inversion seen in the same cycle while idle
    @(negedge clk);
    pol = 2'b11; #1;
    check("R7 invert", 32'(wave_o), 32'd3);
    pol = 2'b00;
    live = 1'b1;

    // R8 directed: mid-ramp write must wait for the next ramp A
    write_reg(2'd0, CW'(9));
    write_reg(2'd1, CW'(5));
    write_reg(2'd2, CW'(4));
    write_reg(2'd3, CW'(3));
    @(negedge clk);
    tick = 1'b1; run = 1'b1; #1;
    hi0 = int'(wave_o[0]);                 // count 0 of ramp A
    check("R9 no strobe on run", 32'({start_a_o, start_b_o}), 32'd0);
    for (int k = 1; k <= 9; k++) begin
      @(posedge clk); #1;
      hi0 += int'(wave_o[0]);
      if (k == 2) begin
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = CW'(8);
      end
      if (k == 3) begin
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    check("R8 old compare kept", 32'(hi0), 32'd4);
    @(posedge clk); #1;
    check("R3 enters ramp B", 32'(ramp_b_o), 32'd1);
    check("R9 start_b pulse", 32'(start_b_o), 32'd1);
    repeat (5) @(posedge clk);
    @(posedge clk); #1;
    check("R4 back to ramp A", 32'(ramp_b_o), 32'd0);
    check("R9 start_a pulse", 32'(start_a_o), 32'd1);
    hi0 = int'(wave_o[0]);
    for (int k = 1; k <= 9; k++) begin
      @(posedge clk); #1;
      hi0 += int'(wave_o[0]);
    end
    check("R8 new compare applied", 32'(hi0), 32'd8);

    // R2: tick low freezes the sequence
    @(negedge clk);
    tick = 1'b0;
    snap_w = wave_o; snap_r = ramp_b_o;
    repeat (20) @(posedge clk);
    #1;
    check("R2 hold wave", 32'(wave_o), 32'(snap_w));
    check("R2 hold ramp", 32'(ramp_b_o), 32'(snap_r));

    // Constrained random phase, checked by the per-cycle model comparison
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      tick    = ($urandom % 4) != 0;
      run     = ($urandom % 64) != 0;
      wr_en   = ($urandom % 8) == 0;
      wr_sel  = 2'($urandom % 4);
      wr_data = CW'($urandom % 12);
      if (($urandom % 50) == 0) pol = 2'($urandom % 4);
    end

    // R10: ramp tops 2500/5000, both compares 1250, full-rate ticks
    @(negedge clk);
    run = 1'b0; wr_en = 1'b0; pol = 2'b00;
    write_reg(2'd0, CW'(2500));
    write_reg(2'd1, CW'(5000));
    write_reg(2'd2, CW'(1250));
    write_reg(2'd3, CW'(1250));
    @(negedge clk);
    tick = 1'b1; run = 1'b1;
    hi0 = 0; hi1 = 0;
    for (int k = 0; k < 7502; k++) begin
      @(posedge clk); #1;
      hi0 += int'(wave_o[0]);
      hi1 += int'(wave_o[1]);
    end
    check("R10 out0 active count", 32'(hi0), 32'd1250);
    check("R10 out1 active count", 32'(hi1), 32'd1250);

    @(negedge clk);
    run = 1'b0;
    @(posedge clk); #1;
    check("R1 stop returns idle", 32'({ramp_b_o, wave_o}), 32'd0);
    live = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule